// File: doc/BRIEF.md
# Saturating Input Glitch Filter

This block removes short spurious pulses from a single-bit input that arrives asynchronously from off-chip wiring. The input first passes through a two-register synchroniser. One of two filtering engines then decides the clean level, and a registered output carries the result. The filter is aimed at noise bursts of about two clocks, which is 200 ns at 10 MHz, riding on a wanted signal whose period is several microseconds.

In integrator mode, a saturating up/down counter rises on every sampled high and falls on every sampled low. The clean level is the counter's top bit. In qualify mode, a run counter measures how many consecutive highs have been seen. The output is raised only after a long enough unbroken run, and any single low sample drops it at once. Both engines run all the time, and `qualMode` picks which one drives the output. The mode is meant to be set while reset is held. Instantiate one copy per input pin.

Top module: `glitch_filter`

## Requirements
- R1: While `rst` is high at a rising edge, `cleanOut`, both counters, the valid flag and the synchroniser are cleared to 0 at that edge.
- R2: `rawIn` is sampled through two register stages before either engine sees it, so no change on `rawIn` reaches `cleanOut` in fewer than three edges.
- R3: In integrator mode (`qualMode`=0), an INT_W-bit counter steps up by one on each synchronised high and down by one on each synchronised low. Starting from an empty counter, a sustained high raises `cleanOut` at the 2^(INT_W-1)+3rd edge after the input change, which is 11 edges for INT_W=4.
- R4: The integrator counter holds at all-ones on further highs and never wraps. After a long high, a sustained low drops `cleanOut` exactly 2^(INT_W-1)+3 edges after the change.
- R5: The integrator counter holds at zero on further lows and never wraps. After a long low, a sustained high raises `cleanOut` exactly 2^(INT_W-1)+3 edges after the change.
- R6: In integrator mode, high pulses shorter than 2^(INT_W-1) cycles on a settled low, and low pulses shorter than 2^(INT_W-1) cycles on a settled high, produce no change on `cleanOut`.
- R7: In qualify mode (`qualMode`=1), every synchronised low sample clears the run counter and the valid flag. A falling input therefore drops `cleanOut` at the 4th edge after the change.
- R8: In qualify mode, the run counter counts synchronised highs up to QUAL_LIMIT and stops there. The valid flag is set only on a high sample taken while the count equals QUAL_LIMIT, so `cleanOut` rises at edge QUAL_LIMIT+4 after a sustained high begins (32 edges for the default of 28).
- R9: In qualify mode, a single-cycle low inside an otherwise high run restarts qualification. `cleanOut` then stays 0 until QUAL_LIMIT+4 edges after the input returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| qualMode | input | 1 | 0 selects the integrator engine, 1 selects the run-qualify engine |
| rawIn | input | 1 | Noisy asynchronous input |
| cleanOut | output | 1 | Registered filtered level |

## Verification
The bound checker watches the counter arithmetic on every cycle. It checks single-step moves in the integrator, holding at both rails, the run counter clearing on any low sample, and the valid flag rising only from a full count. It also checks that reset forces the output low. The exact edge at which `cleanOut` moves, the rejection of glitches of a given width, and the restart of qualification after a one-cycle dropout all depend on whole stimulus sequences, so only the bench's timed scenarios can show them.

// File: rtl/gf_pkg.sv
package gf_pkg;
  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic intUp;
    logic intDown;
    logic qualClr;
    logic qualInc;
    logic qualSet;
  } gf_strobe_t;
endpackage

// File: rtl/gf_sync.sv
module gf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/gf_ctrl.sv
module gf_ctrl
  import gf_pkg::*;
#(
  parameter int QUAL_W     = 5,
  parameter int QUAL_LIMIT = 28
) (
  input  logic              syncIn,
  input  logic              intFull,
  input  logic              intEmpty,
  input  logic [QUAL_W-1:0] qualCnt,
  output gf_strobe_t        strobe
);
  localparam logic [QUAL_W-1:0] QLIM = QUAL_W'(QUAL_LIMIT);

  always_comb begin
    strobe         = '0;
    // integrator: move toward the sampled level, stop at the rails
    strobe.intUp   = syncIn && !intFull;
    strobe.intDown = !syncIn && !intEmpty;
    // qualifier: any low sample restarts the run
    strobe.qualClr = !syncIn;
    strobe.qualInc = syncIn && (qualCnt < QLIM);
    strobe.qualSet = syncIn && (qualCnt == QLIM);
  end
endmodule

// File: rtl/gf_datapath.sv
module gf_datapath
  import gf_pkg::*;
#(
  parameter int INT_W  = 4,
  parameter int QUAL_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              qualMode,
  input  gf_strobe_t        strobe,
  output logic [INT_W-1:0]  intCnt,
  output logic [QUAL_W-1:0] qualCnt,
  output logic              qualValid,
  output logic              intFull,
  output logic              intEmpty,
  output logic              cleanOut
);
  localparam logic [INT_W-1:0] INT_ONE = INT_W'(1);
  localparam logic [QUAL_W-1:0] QUAL_ONE = QUAL_W'(1);

  always_ff @(posedge clk) begin
    if (rst)                 intCnt <= '0;
    else if (strobe.intUp)   intCnt <= intCnt + INT_ONE;
    else if (strobe.intDown) intCnt <= intCnt - INT_ONE;
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.qualClr) qualCnt <= '0;
    else if (strobe.qualInc)   qualCnt <= qualCnt + QUAL_ONE;
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.qualClr) qualValid <= 1'b0;
    else if (strobe.qualSet)   qualValid <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cleanOut <= 1'b0;
    else     cleanOut <= qualMode ? qualValid : intCnt[INT_W-1];
  end

  assign intFull  = &intCnt;
  assign intEmpty = ~|intCnt;
endmodule

// File: rtl/glitch_filter.sv
module glitch_filter
  import gf_pkg::*;
#(
  parameter int INT_W       = 4,
  parameter int QUAL_W      = 5,
  parameter int QUAL_LIMIT  = 28,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic qualMode,
  input  logic rawIn,
  output logic cleanOut
);
  logic              syncIn;
  logic              intFull;
  logic              intEmpty;
  logic              qualValid;
  logic [INT_W-1:0]  intCnt;
  logic [QUAL_W-1:0] qualCnt;
  gf_strobe_t        strobe;

  gf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .asyncIn(rawIn), .syncOut(syncIn)
  );

  gf_ctrl #(.QUAL_W(QUAL_W), .QUAL_LIMIT(QUAL_LIMIT)) u_ctrl (
    .syncIn(syncIn), .intFull(intFull), .intEmpty(intEmpty),
    .qualCnt(qualCnt), .strobe(strobe)
  );

  gf_datapath #(.INT_W(INT_W), .QUAL_W(QUAL_W)) u_dp (
    .clk(clk), .rst(rst), .qualMode(qualMode), .strobe(strobe),
    .intCnt(intCnt), .qualCnt(qualCnt), .qualValid(qualValid),
    .intFull(intFull), .intEmpty(intEmpty), .cleanOut(cleanOut)
  );
endmodule

// File: rtl/gf_checker.sv
module gf_checker #(
  parameter int INT_W      = 4,
  parameter int QUAL_W     = 5,
  parameter int QUAL_LIMIT = 28
) (
  input logic              clk,
  input logic              rst,
  input logic              syncIn,
  input logic [INT_W-1:0]  intCnt,
  input logic [QUAL_W-1:0] qualCnt,
  input logic              qualValid,
  input logic              cleanOut
);
  localparam logic [INT_W-1:0]  IFULL = '1;
  localparam logic [QUAL_W-1:0] QLIM  = QUAL_W'(QUAL_LIMIT);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (cleanOut == 1'b0 && intCnt == '0 && qualCnt == '0)); // R1

  AST_INT_STEP_UP: assert property (@(posedge clk) disable iff (rst)
    (syncIn && intCnt != IFULL) |=> intCnt == INT_W'($past(intCnt) + 1'b1)); // R3

  AST_INT_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (!syncIn && intCnt != '0) |=> intCnt == INT_W'($past(intCnt) - 1'b1)); // R3

  AST_INT_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (rst)
    (syncIn && intCnt == IFULL) |=> intCnt == IFULL); // R4

  AST_INT_NO_WRAP_BOTTOM: assert property (@(posedge clk) disable iff (rst)
    (!syncIn && intCnt == '0) |=> intCnt == '0); // R5

  AST_QUAL_LOW_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !syncIn |=> (qualCnt == '0 && !qualValid)); // R7

  AST_QUAL_CAPPED: assert property (@(posedge clk) disable iff (rst)
    qualCnt <= QLIM); // R8

  AST_QUAL_SET_FROM_FULL: assert property (@(posedge clk) disable iff (rst)
    $rose(qualValid) |-> ($past(qualCnt) == QLIM && $past(syncIn))); // R8
endmodule

bind glitch_filter gf_checker #(
  .INT_W(INT_W), .QUAL_W(QUAL_W), .QUAL_LIMIT(QUAL_LIMIT)
) u_chk (
  .clk(clk), .rst(rst), .syncIn(syncIn), .intCnt(intCnt),
  .qualCnt(qualCnt), .qualValid(qualValid), .cleanOut(cleanOut)
);

// File: tb/glitch_filter_tb.sv
module glitch_filter_tb;
  localparam int INT_W      = 4;
  localparam int QUAL_LIMIT = 28;
  localparam int LAT_INT    = (1 << (INT_W - 1)) + 3;  // 11
  localparam int LAT_QUP    = QUAL_LIMIT + 4;          // 32
  localparam int LAT_QDN    = 4;

  typedef struct {
    int    cyc;
    bit    val;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic qualMode = 1'b0;
  logic rawIn = 1'b0;
  logic cleanOut;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  item_t sb[$];

  glitch_filter #(.INT_W(INT_W), .QUAL_LIMIT(QUAL_LIMIT)) u_dut (
    .clk(clk), .rst(rst), .qualMode(qualMode), .rawIn(rawIn), .cleanOut(cleanOut)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Driver side: push expected output value for an absolute cycle
  task automatic expectAt(int at, bit v, string tag);
    item_t it;
    it.cyc = at; it.val = v; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic expectSpan(int from, int to, bit v, string tag);
    for (int k = from; k <= to; k++) expectAt(k, v, tag);
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compare at negedge, away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (it.cyc < cyc) begin
        errors++;
        $display("FAIL %s: item for cycle %0d missed (now %0d)", it.tag, it.cyc, cyc);
      end else if (cleanOut !== it.val) begin
        errors++;
        $display("FAIL %s: cycle %0d cleanOut=%b expected %b", it.tag, cyc, cleanOut, it.val);
      end
    end
  end

  initial begin : watchdog
    #(8 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    int b;
    waitCyc(1);
    expectSpan(cyc + 1, cyc + 3, 1'b0, "R1");   // reset state
    waitCyc(3);
    rst = 1'b0;
    waitCyc(5);

    // R3/R2: rise from empty integrator
    b = cyc; rawIn = 1'b1;
    expectSpan(b + 1, b + LAT_INT - 1, 1'b0, "R2");
    expectAt(b + LAT_INT, 1'b1, "R3");
    waitCyc(30);

    // R6: 2-cycle low glitch on a settled high
    b = cyc;
    expectSpan(b + 1, b + 20, 1'b1, "R6");
    rawIn = 1'b0; waitCyc(2); rawIn = 1'b1;
    waitCyc(25);

    // R4: fall from saturated top, exact latency proves no wrap
    b = cyc; rawIn = 1'b0;
    expectAt(b + LAT_INT - 1, 1'b1, "R4");
    expectAt(b + LAT_INT, 1'b0, "R4");
    waitCyc(30);

    // R6: repeated 3-cycle high glitches on a settled low
    b = cyc;
    expectSpan(b + 1, b + 40, 1'b0, "R6");
    for (int g = 0; g < 3; g++) begin
      rawIn = 1'b1; waitCyc(3);
      rawIn = 1'b0; waitCyc(8);
    end
    waitCyc(10);

    // R5: rise from saturated bottom
    b = cyc; rawIn = 1'b1;
    expectAt(b + LAT_INT - 1, 1'b0, "R5");
    expectAt(b + LAT_INT, 1'b1, "R5");
    waitCyc(20);

    // R1: reset while output high, switch to qualify mode
    rst = 1'b1; rawIn = 1'b0; qualMode = 1'b1;
    expectSpan(cyc + 1, cyc + 3, 1'b0, "R1");
    waitCyc(3);
    rst = 1'b0;
    waitCyc(3);

    // R8: qualified rise
    b = cyc; rawIn = 1'b1;
    expectSpan(b + 1, b + LAT_QUP - 1, 1'b0, "R8");
    expectAt(b + LAT_QUP, 1'b1, "R8");
    waitCyc(40);

    // R7: any low drops output
    b = cyc; rawIn = 1'b0;
    expectAt(b + LAT_QDN - 1, 1'b1, "R7");
    expectAt(b + LAT_QDN, 1'b0, "R7");
    waitCyc(6);

    // R9: one-cycle dropout restarts qualification
    b = cyc; rawIn = 1'b1;
    expectSpan(b + 1, b + 20, 1'b0, "R9");
    waitCyc(20);
    rawIn = 1'b0;
    expectAt(cyc + 1, 1'b0, "R9");
    waitCyc(1);
    b = cyc; rawIn = 1'b1;
    expectSpan(b + 1, b + LAT_QUP - 1, 1'b0, "R9");
    expectAt(b + LAT_QUP, 1'b1, "R9");
    waitCyc(LAT_QUP + 4);

    waitCyc(2);
    if (sb.size() != 0) begin
      errors++;
      checks++;
      $display("FAIL scoreboard: %0d items unchecked, expected 0", sb.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule